// File: doc/BRIEF.md
# Timed Date Display Sequencer

This block drives a pair of seven-segment digits through a loop that shows a date. The loop has four timed phases. The first shows the month, the second shows the day of the month, the third switches both digits off, and the fourth shows the two low digits of the year. The loop then starts again at the month phase and runs without end. Six BCD digit inputs supply the date: tens and ones for each of month, day and year. A leading zero is shown as a real digit, so July appears as 0 then 7.

Phase timing comes from a seconds tick. The tick is made by dividing the system clock by the parameter `TICKS_PER_SEC`. Its default of 50,000,000 suits a 50 MHz clock, and a bench can set it to a small value. The month, day and year phases each last one second. The blank phase lasts two seconds, so one full loop takes five seconds.

Each digit drives an active-low 8-bit segment pattern with the decimal point in the top bit. A small phase code tells the surrounding logic which part of the date is on show. Both segment outputs are registered.

Top module: `date_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `phase` becomes 0 (month) and both segment outputs become 8'hFF. After `rst` falls, the first phase change comes exactly `TICKS_PER_SEC` cycles later.
- R2: In the month phase (`phase` = 0), `seg_hi` shows `month_tens` and `seg_lo` shows `month_ones`. The phase lasts one second, which is `TICKS_PER_SEC` cycles.
- R3: In the day phase (`phase` = 1), `seg_hi` shows `day_tens` and `seg_lo` shows `day_ones`. The phase lasts one second.
- R4: In the blank phase (`phase` = 2), both segment outputs are 8'hFF. The phase lasts two seconds.
- R5: In the year phase (`phase` = 3), `seg_hi` shows `year_tens` and `seg_lo` shows `year_ones`. The phase lasts one second.
- R6: The phases run in the order 0, 1, 2, 3 and then back to 0, with no end. One full loop is 5 × `TICKS_PER_SEC` cycles.
- R7: A seconds tick ends every `TICKS_PER_SEC` cycles, counted from reset. `phase` changes on the clock edge of the tick that closes the dwell time, and on no other edge.
- R8: Segment codes are active low, with bit 7 the decimal point. The values are: 0=C0, 1=F9, 2=A4, 3=B0, 4=99, 5=92, 6=82, 7=F8, 8=80, 9=98 (hex). The decimal point is never lit.
- R9: A BCD input with a value from 10 to 15 gives 8'hFF on the digit it drives.
- R10: The segment outputs are registered one stage behind `phase`. After any clock edge they show the decoded digits of the phase that was current before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| month_tens | input | 4 | BCD tens digit of the month |
| month_ones | input | 4 | BCD ones digit of the month |
| day_tens | input | 4 | BCD tens digit of the day |
| day_ones | input | 4 | BCD ones digit of the day |
| year_tens | input | 4 | BCD tens digit of the year |
| year_ones | input | 4 | BCD ones digit of the year |
| seg_hi | output | 8 | Active-low segments of the left digit, decimal point in bit 7 |
| seg_lo | output | 8 | Active-low segments of the right digit, decimal point in bit 7 |
| phase | output | 2 | Current phase: 0 month, 1 day, 2 blank, 3 year |

## Verification
The checker assumes that `rst` is held for at least one clock edge before timing starts. It also assumes that `TICKS_PER_SEC` is small enough for a 32-bit run counter to hold two seconds of cycles. The checker does not look at the digit inputs, so it makes no assumption about their values. The stimulus changes digits only while reset is high, so each run sees a steady date. Over sixteen runs, every digit input takes every 4-bit value, and that includes the illegal codes 10 to 15.

// File: rtl/date_seq_pkg.sv
package date_seq_pkg;

  typedef enum logic [1:0] {
    PH_MONTH = 2'd0,
    PH_DAY   = 2'd1,
    PH_BLANK = 2'd2,
    PH_YEAR  = 2'd3
  } phase_e;

  localparam logic [7:0] SEG_DARK = 8'hFF;
  localparam int unsigned DWELL_W = 2;

  // Length of each phase, counted in seconds.
  function automatic logic [DWELL_W-1:0] dwell_secs(phase_e p);
    if (p == PH_BLANK) return 2'd2;
    return 2'd1;
  endfunction

  function automatic phase_e phase_after(phase_e p);
    case (p)
      PH_MONTH: return PH_DAY;
      PH_DAY:   return PH_BLANK;
      PH_BLANK: return PH_YEAR;
      default:  return PH_MONTH;
    endcase
  endfunction

endpackage

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
  parameter int unsigned TICKS = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // High in the last cycle of each second.
  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import date_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_i,
  output phase_e phase_o
);
  phase_e             ph_q;
  logic [DWELL_W-1:0] secs_q;
  logic               dwell_done;

  assign dwell_done = (secs_q == dwell_secs(ph_q) - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_MONTH;
      secs_q <= '0;
    end else if (tick_i) begin
      if (dwell_done) begin
        ph_q   <= phase_after(ph_q);
        secs_q <= '0;
      end else begin
        secs_q <= secs_q + 1'b1;
      end
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/bcd_seg_dec.sv
module bcd_seg_dec
  import date_seq_pkg::*;
(
  input  logic [3:0] bcd_i,
  input  logic       dark_i,
  output logic [7:0] seg_o
);
  always_comb begin
    if (dark_i) seg_o = SEG_DARK;
    else begin
      case (bcd_i)
        4'd0: seg_o = 8'hC0;
        4'd1: seg_o = 8'hF9;
        4'd2: seg_o = 8'hA4;
        4'd3: seg_o = 8'hB0;
        4'd4: seg_o = 8'h99;
        4'd5: seg_o = 8'h92;
        4'd6: seg_o = 8'h82;
        4'd7: seg_o = 8'hF8;
        4'd8: seg_o = 8'h80;
        4'd9: seg_o = 8'h98;
        default: seg_o = SEG_DARK;
      endcase
    end
  end
endmodule

// File: rtl/date_seq_top.sv
module date_seq_top
  import date_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] month_tens,
  input  logic [3:0] month_ones,
  input  logic [3:0] day_tens,
  input  logic [3:0] day_ones,
  input  logic [3:0] year_tens,
  input  logic [3:0] year_ones,
  output logic [7:0] seg_hi,
  output logic [7:0] seg_lo,
  output logic [1:0] phase
);
  localparam int unsigned NDIG = 2;

  logic       tick;
  phase_e     ph;
  logic [3:0] dig   [NDIG];
  logic [7:0] seg_d [NDIG];
  logic [7:0] seg_q [NDIG];
  logic       dark;

  sec_tick_gen #(.TICKS(TICKS_PER_SEC)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  phase_fsm u_fsm (
    .clk(clk), .rst(rst), .tick_i(tick), .phase_o(ph)
  );

  // Choose the digits that the current phase puts on show. Index 0 is the
  // left digit.
  always_comb begin
    dark = 1'b0;
    case (ph)
      PH_MONTH: begin dig[0] = month_tens; dig[1] = month_ones; end
      PH_DAY:   begin dig[0] = day_tens;   dig[1] = day_ones;   end
      PH_YEAR:  begin dig[0] = year_tens;  dig[1] = year_ones;  end
      default:  begin dig[0] = 4'd0; dig[1] = 4'd0; dark = 1'b1; end
    endcase
  end

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    bcd_seg_dec u_dec (.bcd_i(dig[g]), .dark_i(dark), .seg_o(seg_d[g]));

    always_ff @(posedge clk) begin
      if (rst) seg_q[g] <= SEG_DARK;
      else     seg_q[g] <= seg_d[g];
    end
  end

  assign seg_hi = seg_q[0];
  assign seg_lo = seg_q[1];
  assign phase  = ph;
endmodule

// File: rtl/date_seq_chk.sv
module date_seq_chk #(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase,
  input logic [7:0] seg_hi,
  input logic [7:0] seg_lo
);
  logic        armed;
  logic        seen_step;
  logic [1:0]  prev_ph;
  logic [31:0] run;
  logic        stepped;

  assign stepped = armed && (phase != prev_ph);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      seen_step <= 1'b0;
      prev_ph   <= 2'd0;
      run       <= '0;
    end else begin
      armed   <= 1'b1;
      prev_ph <= phase;
      if (stepped) begin
        run       <= 32'd1;
        seen_step <= 1'b1;
      end else begin
        run <= run + 32'd1;
      end
    end
  end

  // R6
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    stepped |-> phase == prev_ph + 2'd1);

  // R7
  dwell_len_chk: assert property (@(posedge clk) disable iff (rst)
    (stepped && seen_step) |->
      run == ((prev_ph == 2'd2) ? 32'(2 * TICKS_PER_SEC) : 32'(TICKS_PER_SEC)));

  // R4
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && prev_ph == 2'd2) |-> (seg_hi == 8'hFF && seg_lo == 8'hFF));

  // R8
  dp_off_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (seg_hi[7] && seg_lo[7]));
endmodule

bind date_seq_top date_seq_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .seg_hi(seg_hi), .seg_lo(seg_lo)
);

// File: tb/tb_date_seq_top.sv
module tb_date_seq_top;
  localparam int TPS = 4;
  localparam int RUN_EDGES = 2 * 5 * TPS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] mt = 0, mo = 0, dt = 0, dd = 0, yt = 0, yo = 0;
  logic [7:0] seg_hi, seg_lo;
  logic [1:0] phase;

  int tests = 0;
  int fails = 0;
  int wd = 0;

  always #10 clk = ~clk;

  date_seq_top #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst(rst),
    .month_tens(mt), .month_ones(mo), .day_tens(dt), .day_ones(dd),
    .year_tens(yt), .year_ones(yo),
    .seg_hi(seg_hi), .seg_lo(seg_lo), .phase(phase)
  );

  function automatic logic [7:0] enc(input logic [3:0] d);
    logic [7:0] t [10] = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99,
                           8'h92, 8'h82, 8'hF8, 8'h80, 8'h98};
    if (d > 4'd9) return 8'hFF;
    return t[d];
  endfunction

  // Phase in force after n edges out of reset.
  function automatic logic [1:0] exp_phase(input int n);
    int s = (n / TPS) % 5;
    if (s == 0) return 2'd0;
    if (s == 1) return 2'd1;
    if (s == 4) return 2'd3;
    return 2'd2;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      rst = 1'b1;
      mt = 4'(v); mo = 4'(v + 3); dt = 4'(v + 5);
      dd = 4'(v + 7); yt = 4'(v + 11); yo = 4'(v + 13);
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 phase", {6'd0, phase}, 8'd0);
      chk("R1 seg_hi", seg_hi, 8'hFF);
      chk("R1 seg_lo", seg_lo, 8'hFF);
      rst = 1'b0;
      for (int n = 1; n <= RUN_EDGES; n++) begin
        logic [1:0] pp;
        logic [7:0] eh, el;
        string tag;
        @(negedge clk);
        // R6 R7 phase order and tick timing
        chk("R6 R7 phase", {6'd0, phase}, {6'd0, exp_phase(n)});
        pp = exp_phase(n - 1);
        case (pp)
          2'd0: begin eh = enc(mt); el = enc(mo); tag = "R2 R8 R9 month"; end
          2'd1: begin eh = enc(dt); el = enc(dd); tag = "R3 R8 R9 day"; end
          2'd3: begin eh = enc(yt); el = enc(yo); tag = "R5 R8 R9 year"; end
          default: begin eh = 8'hFF; el = 8'hFF; tag = "R4 blank"; end
        endcase
        // R10: segments follow the phase held before the edge
        if (n % TPS == 0) tag = {tag, " R10"};
        chk(tag, seg_hi, eh);
        chk(tag, seg_lo, el);
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule